// File: doc/BRIEF.md
# Microwire Configuration-Memory Slave

This block is the slave end of a four-wire Microwire link to a small configuration store of 64 words × 16 bits. The store is held in registers. A host selects the device with `cs`, clocks serial bits on `sk`, and sends them on `di`. The block decodes a start bit, a two-bit opcode and a six-bit address, in that order, and then runs one of five commands: read, write, write-enable, write-disable or write-all. Read data and ready/busy status return on `do_o`. `do_en` is the output-enable for an external tri-state buffer, so the pin floats whenever `do_en` is low.

Writes are guarded by an enable latch. The latch is clear after reset, so a host must send the enable command first. A complete write or write-all is held until `cs` falls. The programming cycle then runs on its own for `WR_CYCLES` clock cycles, with no further serial clocks. While the cycle runs, a host that raises `cs` sees busy and then ready on `do_o`.

The serial inputs are sampled on `clk`, which must be much faster than `sk`. A rising `sk` acts on the next `clk` edge.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, `do_en` is low, the enable latch is clear, no programming cycle is running and every word reads as zero.
- R2: A command starts with the first `di`=1 sampled on a rising `sk` edge; earlier 0 bits are ignored. Two opcode bits follow, then six address bits, all MSB first. Opcode 10 is read and 01 is write. With opcode 00, the two upper address bits select the function: 11 enable, 00 disable, 01 write-all; 10 does nothing. Opcode 11 does nothing.
- R3: On a read, the rising `sk` edge that carries the last address bit sets `do_en` high and `do_o` to 0. Each of the next 16 rising `sk` edges presents one bit of the addressed word, MSB first.
- R4: One clock after `cs` is low, `do_en` is low.
- R5: A write or write-all that arrives while the enable latch is clear starts no programming cycle and changes no word.
- R6: The enable latch stays set until a disable command is received or reset is applied. After a disable, writes are refused again. Reads work in either state.
- R7: A write carries 16 data bits MSB first after the address. Programming starts when `cs` falls after the command is complete, runs for exactly `WR_CYCLES` clock cycles, and then updates the addressed word.
- R8: A write-all carries 16 data bits and, once its programming cycle ends, writes that word to all 64 locations.
- R9: If `cs` rises while a programming cycle runs, `do_en` goes high with `do_o` low (busy). `do_o` goes high (ready) once the cycle ends, and stays so until `cs` falls.
- R10: Serial bits sent during a selection that began while programming was running are not decoded.
- R11: A selection that starts after fewer than `CSL_MIN` clock cycles with `cs` low is ignored entirely.
- R12: If `cs` falls before all 16 data bits of a write have arrived, no programming cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host; its rising edge shifts data |
| di | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial read data or ready/busy status |
| do_en | output | 1 | Output enable for `do_o`; low means high-impedance |

## Verification
The assertions assume that `cs`, `sk` and `di` are synchronous to `clk`, and that each `sk` level is held for at least one clock. They also assume that a deselect between selections lasts at least `CSL_MIN` cycles, with `CSL_MIN` of two or more, so the programming cycle has already started before a status poll can begin. The stimulus changes every input on the falling edge of `clk` and holds each `sk` level for one full clock. A normal deselect lasts `CSL_MIN`+2 cycles. The one scenario that breaks the deselect rule does so on purpose, to check that the short selection is ignored.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_READ,
        PH_DONE
    } phase_e;

    localparam logic [1:0] OPC_CTRL  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_WDIS = 2'b00;
    localparam logic [1:0] SUB_WALL = 2'b01;
    localparam logic [1:0] SUB_ERAL = 2'b10;
    localparam logic [1:0] SUB_WEN  = 2'b11;

endpackage

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int WR_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (done) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(WR_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_one,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_comb begin
            mem_d[i] = mem_q[i];
            if (wr_all || (wr_one && (waddr == ADDR_W'(i)))) mem_d[i] = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mw_serial_ctrl.sv
module mw_serial_ctrl
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int CSL_MIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sk,
    input  logic              di,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              do_o,
    output logic              do_en,
    output logic              wen,
    output logic              prog_req,
    output logic              prog_all,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);
    localparam int MAXB  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXB + 1);
    localparam int LOW_W = $clog2(CSL_MIN + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] sreg;
        logic              dout;
        logic              doe;
        logic              wen;
        logic              status;
        logic              skip;
        logic              pend;
        logic              pall;
        logic              req;
        logic [LOW_W-1:0]  lowcnt;
        logic              sk_prev;
        logic              cs_prev;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic              sk_rise;
    logic [ADDR_W-1:0] addr_nxt;
    logic [DATA_W-1:0] word;

    assign sk_rise  = sk && !ctl_q.sk_prev;
    assign addr_nxt = {ctl_q.addr[ADDR_W-2:0], di};

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.sk_prev = sk;
        ctl_d.cs_prev = cs;
        ctl_d.req     = 1'b0;
        word          = (ctl_q.cnt == '0) ? rd_word : ctl_q.sreg;

        if (!cs) begin
            // deselected: float the pin, release a complete write
            ctl_d.phase  = PH_IDLE;
            ctl_d.cnt    = '0;
            ctl_d.doe    = 1'b0;
            ctl_d.status = 1'b0;
            ctl_d.skip   = 1'b0;
            ctl_d.pend   = 1'b0;
            if (ctl_q.cs_prev && ctl_q.pend) ctl_d.req = 1'b1;
            if (ctl_q.lowcnt != LOW_W'(CSL_MIN)) ctl_d.lowcnt = ctl_q.lowcnt + 1'b1;
        end else if (!ctl_q.cs_prev) begin
            // new selection: qualify it and decide on status polling
            ctl_d.skip   = (ctl_q.lowcnt < LOW_W'(CSL_MIN));
            ctl_d.status = busy;
            ctl_d.doe    = busy;
            ctl_d.dout   = 1'b0;
            ctl_d.lowcnt = '0;
        end else if (ctl_q.status) begin
            ctl_d.doe  = 1'b1;
            ctl_d.dout = !busy;
        end else if (!ctl_q.skip && sk_rise) begin
            unique case (ctl_q.phase)
                PH_IDLE: begin
                    if (di) begin
                        ctl_d.phase = PH_OPC;
                        ctl_d.cnt   = '0;
                    end
                end
                PH_OPC: begin
                    ctl_d.opc = {ctl_q.opc[0], di};
                    if (ctl_q.cnt == CNT_W'(1)) begin
                        ctl_d.phase = PH_ADDR;
                        ctl_d.cnt   = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
                PH_ADDR: begin
                    ctl_d.addr = addr_nxt;
                    ctl_d.cnt  = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == ADDR_LAST) begin
                        ctl_d.cnt   = '0;
                        ctl_d.phase = PH_DONE;
                        unique case (ctl_q.opc)
                            OPC_READ: begin
                                ctl_d.phase = PH_READ;
                                ctl_d.doe   = 1'b1;
                                ctl_d.dout  = 1'b0;
                            end
                            OPC_WRITE: begin
                                ctl_d.phase = PH_DATA;
                                ctl_d.pall  = 1'b0;
                            end
                            OPC_CTRL: begin
                                unique case (addr_nxt[ADDR_W-1 -: 2])
                                    SUB_WEN:  ctl_d.wen = 1'b1;
                                    SUB_WDIS: ctl_d.wen = 1'b0;
                                    SUB_WALL: begin
                                        ctl_d.phase = PH_DATA;
                                        ctl_d.pall  = 1'b1;
                                    end
                                    SUB_ERAL: ctl_d.phase = PH_DONE;
                                endcase
                            end
                            OPC_ERASE: ctl_d.phase = PH_DONE;
                        endcase
                    end
                end
                PH_DATA: begin
                    ctl_d.sreg = {ctl_q.sreg[DATA_W-2:0], di};
                    ctl_d.cnt  = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == DATA_LAST) begin
                        ctl_d.pend  = ctl_q.wen;
                        ctl_d.phase = PH_DONE;
                    end
                end
                PH_READ: begin
                    ctl_d.dout = word[DATA_W-1];
                    ctl_d.sreg = {word[DATA_W-2:0], 1'b0};
                    ctl_d.cnt  = ctl_q.cnt + 1'b1;
                    if (ctl_q.cnt == DATA_LAST) ctl_d.phase = PH_DONE;
                end
                PH_DONE: ctl_d.phase = PH_DONE;
                default: ctl_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.lowcnt <= LOW_W'(CSL_MIN);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_addr   = ctl_q.addr;
    assign do_o      = ctl_q.dout;
    assign do_en     = ctl_q.doe;
    assign wen       = ctl_q.wen;
    assign prog_req  = ctl_q.req;
    assign prog_all  = ctl_q.pall;
    assign prog_addr = ctl_q.addr;
    assign prog_data = ctl_q.sreg;
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int WR_CYCLES = 32,
    parameter int CSL_MIN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_en
);
    logic              prog_busy;
    logic              prog_done;
    logic              prog_req;
    logic              prog_all;
    logic              wr_enabled;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] prog_addr;
    logic [DATA_W-1:0] prog_data;
    logic [DATA_W-1:0] rd_word;

    mw_serial_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CSL_MIN(CSL_MIN)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs       (cs),
        .sk       (sk),
        .di       (di),
        .busy     (prog_busy),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .do_o     (do_o),
        .do_en    (do_en),
        .wen      (wr_enabled),
        .prog_req (prog_req),
        .prog_all (prog_all),
        .prog_addr(prog_addr),
        .prog_data(prog_data)
    );

    mw_prog_timer #(
        .WR_CYCLES(WR_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(prog_req),
        .busy (prog_busy),
        .done (prog_done)
    );

    mw_word_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_one(prog_done && !prog_all),
        .wr_all(prog_done && prog_all),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (rd_addr),
        .rdata (rd_word)
    );
endmodule

// File: rtl/mw_eeprom_sva.sv
module mw_eeprom_sva #(
    parameter int WR_CYCLES = 32
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic do_o,
    input logic do_en,
    input logic busy,
    input logic wen
);
    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_hiz_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !do_en);

    assert_first_drive_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(do_en) |-> !do_o);

    assert_busy_reads_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && do_en) |-> !do_o);

    assert_locked_no_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wen));

    assert_prog_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == WR_CYCLES));
endmodule

bind mw_eeprom_slave mw_eeprom_sva #(
    .WR_CYCLES(WR_CYCLES)
) u_sva (
    .clk  (clk),
    .rst_n(rst_n),
    .cs   (cs),
    .do_o (do_o),
    .do_en(do_en),
    .busy (prog_busy),
    .wen  (wr_enabled)
);

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int WR_CYC     = 32;
    localparam int CSL        = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_en;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    mw_eeprom_slave #(.ADDR_W(6), .DATA_W(16), .WR_CYCLES(WR_CYC), .CSL_MIN(CSL)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_en(do_en));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        di = b; sk = 1'b1;
        @(negedge clk); sk = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic select_dev();
        @(negedge clk); cs = 1'b1;
        wait_clk(2);
    endtask

    task automatic deselect_dev();
        cs = 1'b0;
        wait_clk(CSL + 2);
    endtask

    task automatic do_read(input logic [5:0] a, input int lead0, output logic [15:0] w, output logic dummy, output logic oe);
        select_dev();
        send(0, lead0);
        send({1'b1, 2'b10, a}, 9);
        dummy = do_o; oe = do_en;
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0);
            w[i] = do_o;
        end
        deselect_dev();
    endtask

    task automatic read_expect(input logic [5:0] a, input logic [15:0] exp, input string req);
        logic [15:0] w; logic dm, oe;
        do_read(a, 0, w, dm, oe);
        check(w == exp, req, w, exp);
    endtask

    task automatic ctrl_cmd(input logic [1:0] sub);
        select_dev();
        send({1'b1, 2'b00, sub, 4'b0000}, 9);
        deselect_dev();
    endtask

    task automatic write_cmd(input logic [5:0] a, input logic [15:0] d, input bit all);
        select_dev();
        if (all) send({1'b1, 2'b00, 6'b010000}, 9);
        else     send({1'b1, 2'b01, a}, 9);
        send(d, 16);
        deselect_dev();
    endtask

    task automatic t_reset();
        logic [15:0] w; logic dm, oe;
        check(do_en == 1'b0, "R1 do_en after reset", do_en, 0);
        do_read(6'd0, 0, w, dm, oe);
        check(w == 16'h0, "R1 word0 after reset", w, 0);
        check(oe == 1'b1, "R3 do_en during read", oe, 1);
        check(dm == 1'b0, "R3 dummy bit", dm, 0);
        check(do_en == 1'b0, "R4 float after deselect", do_en, 0);
        read_expect(6'd37, 16'h0, "R1 word37 after reset");
    endtask

    task automatic t_locked_write();
        write_cmd(6'd3, 16'hA5A5, 0);
        select_dev();
        check(do_en == 1'b0, "R5 no busy when locked", do_en, 0);
        deselect_dev();
        read_expect(6'd3, 16'h0, "R5 locked write ignored");
    endtask

    task automatic t_write_status();
        ctrl_cmd(2'b11);
        write_cmd(6'd3, 16'h1234, 0);
        select_dev();
        check(do_en == 1'b1, "R9 status driven", do_en, 1);
        check(do_o == 1'b0, "R9 busy low", do_o, 0);
        wait_clk(WR_CYC + 4);
        check(do_o == 1'b1, "R9 ready high", do_o, 1);
        cs = 1'b0;
        @(negedge clk);
        check(do_en == 1'b0, "R4 float after status", do_en, 0);
        wait_clk(CSL + 2);
        read_expect(6'd3, 16'h1234, "R7 written word");
        read_expect(6'd4, 16'h0, "R7 neighbour untouched");
    endtask

    task automatic t_busy_ignore();
        write_cmd(6'd7, 16'hBEEF, 0);
        select_dev();
        send({1'b1, 2'b01, 6'd8}, 9);
        send(16'h1111, 16);
        deselect_dev();
        wait_clk(WR_CYC + 4);
        read_expect(6'd8, 16'h0, "R10 command during busy ignored");
        read_expect(6'd7, 16'hBEEF, "R7 second write");
    endtask

    task automatic t_abort();
        select_dev();
        send({1'b1, 2'b01, 6'd9}, 9);
        send(10'h3FF, 10);
        deselect_dev();
        select_dev();
        check(do_en == 1'b0, "R12 no busy after abort", do_en, 0);
        deselect_dev();
        read_expect(6'd9, 16'h0, "R12 aborted write");
    endtask

    task automatic t_short_deselect();
        select_dev();
        cs = 1'b0;
        @(negedge clk);
        cs = 1'b1;
        wait_clk(2);
        send({1'b1, 2'b01, 6'd10}, 9);
        send(16'hC3C3, 16);
        deselect_dev();
        wait_clk(WR_CYC + 4);
        read_expect(6'd10, 16'h0, "R11 short deselect ignored");
    endtask

    task automatic t_disable();
        ctrl_cmd(2'b00);
        write_cmd(6'd3, 16'hFFFF, 0);
        wait_clk(WR_CYC + 4);
        read_expect(6'd3, 16'h1234, "R6 write refused after disable");
    endtask

    task automatic t_write_all();
        logic [15:0] w; logic dm, oe;
        ctrl_cmd(2'b11);
        ctrl_cmd(2'b10);
        write_cmd(6'd0, 16'h5A5A, 1);
        wait_clk(WR_CYC + 4);
        read_expect(6'd0, 16'h5A5A, "R8 word0");
        read_expect(6'd10, 16'h5A5A, "R8 word10");
        do_read(6'd63, 2, w, dm, oe);
        check(w == 16'h5A5A, "R2 leading zeros then R8 word63", w, 16'h5A5A);
    endtask

    task automatic t_rereset();
        @(negedge clk); rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        read_expect(6'd7, 16'h0, "R1 cleared by reset");
        write_cmd(6'd7, 16'h7777, 0);
        wait_clk(WR_CYC + 4);
        read_expect(6'd7, 16'h0, "R6 enable cleared by reset");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_locked_write();
        t_write_status();
        t_busy_ignore();
        t_abort();
        t_short_deselect();
        t_disable();
        t_write_all();
        t_rereset();
        finish_run();
    end
endmodule